// File: doc/BRIEF.md
# SPI Command Slave with Status Polling

This block connects an SPI master to a processing engine whose work takes much longer than one SPI byte. The master talks to it with one-byte commands. A start command launches the engine. A status command returns, in the very next byte, a code for idle, busy or done. A read command shifts out the stored result. The master learns that the work is finished only by polling the status byte, so the link needs only the four SPI wires and no extra handshake pin.

The SPI pins are sampled by the system clock through two-flop synchronizers. Frames use SPI mode 0, most significant bit first, and are framed by an active-low select. The first byte of each frame is the command. The answer starts in the second byte. On the engine side there is a one-cycle start pulse, a one-cycle done pulse and a result bus. The result bus is captured when the done pulse arrives, so the result is held ready to shift out at once.

Top module: `spi_cmd_poll_slave`

## Requirements
- R1: The status takes only the codes 0x00 (idle), 0x01 (busy) and 0x02 (done). Reset leaves it idle, with `miso` and `eng_start` low.
- R2: Command 0x10, received while idle, raises `eng_start` for exactly one clock and moves the status to busy.
- R3: After command 0x20, the byte that immediately follows carries the current status code. Every further byte in the same frame carries the status as it stands when that byte is loaded.
- R4: A pulse on `eng_done` while busy captures `eng_result` and moves the status to done.
- R5: Command 0x30, received while done, returns the result most significant byte first over the next RES_BYTES bytes. Any later bytes in that frame return 0x00. Completing byte RES_BYTES returns the status to idle. A frame that ends earlier leaves the status at done.
- R6: Command 0x30, received while not done, answers 0xFF in every following byte and leaves the status unchanged.
- R7: Command 0x10, received while busy or done, produces no `eng_start` pulse and leaves the status unchanged.
- R8: Any other command code answers 0x00 and changes nothing. `miso` is 0x00 during the command byte and low while `cs_n` is high.
- R9: Mode 0 framing: `mosi` is sampled on rising `sclk`, `miso` changes after falling `sclk`, data is MSB first, and raising `cs_n` aborts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from master |
| cs_n | input | 1 | SPI select, active low |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_result | input | RES_BYTES*8 | Engine result, captured on `eng_done` |

## Verification
The assertions assume that `eng_done` pulses only after a launch, and that each `sclk` level and each `cs_n` setup lasts at least four system clocks, so that every edge survives the synchronizers. The bench engine model pulses done a fixed delay after each start and clears itself on reset. The bench master holds every SPI level for six clocks. Under these conditions the status must follow idle to busy to done to idle and never jump from idle straight to done.

// File: rtl/spi_cmd_poll_slave.sv
module spi_cmd_poll_slave #(
  parameter int RES_BYTES = 4,
  parameter logic [7:0] CMD_GO   = 8'h10,
  parameter logic [7:0] CMD_STAT = 8'h20,
  parameter logic [7:0] CMD_READ = 8'h30
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   cs_n,
  input  logic                   mosi,
  output logic                   miso,
  output logic                   eng_start,
  input  logic                   eng_done,
  input  logic [RES_BYTES*8-1:0] eng_result
);
  localparam int RES_W = RES_BYTES * 8;
  localparam int BW    = $clog2(RES_BYTES + 2);
  localparam logic [BW-1:0] IDX_MAX  = BW'(RES_BYTES + 1);
  localparam logic [BW-1:0] IDX_LAST = BW'(RES_BYTES);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_DONE = 2'd2;

  logic [2:0] sclk_s, cs_s;
  logic [1:0] mosi_s;
  logic [1:0] status_q;
  logic [2:0] bit_cnt;
  logic [BW-1:0] byte_idx;
  logic [7:0] rx_q, tx_q, cmd_q, resp;
  logic rd_ok_q;
  logic [RES_W-1:0] res_q;

  wire sel     = ~cs_s[1];
  wire cs_fall = cs_s[2] & ~cs_s[1];
  wire rise    = sel & sclk_s[1] & ~sclk_s[2];
  wire fall    = sel & ~sclk_s[1] & sclk_s[2];
  wire [7:0] rx_full = {rx_q[6:0], mosi_s[1]};
  wire byte_end = rise & (bit_cnt == 3'd7);
  wire first    = (byte_idx == '0);
  wire [7:0] cmd_n   = first ? rx_full : cmd_q;
  wire       rd_ok_n = first ? (status_q == ST_DONE) : rd_ok_q;
  wire go_fire  = byte_end & first & (rx_full == CMD_GO) & (status_q == ST_IDLE);
  wire rd_fin   = byte_end & (byte_idx == IDX_LAST) & (cmd_q == CMD_READ) & rd_ok_q;

  assign miso = sel & tx_q[7];

  always_comb begin
    int k;
    logic [RES_W-1:0] sh;
    k = 32'(byte_idx) + 1;
    sh = '0;
    resp = 8'h00;
    if (cmd_n == CMD_STAT) begin
      resp = {6'd0, status_q};
    end else if (cmd_n == CMD_READ) begin
      if (!rd_ok_n) resp = 8'hFF;
      else if (k <= RES_BYTES) begin
        sh = res_q >> (8 * (RES_BYTES - k));
        resp = sh[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[1:0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      cmd_q    <= '0;
      rd_ok_q  <= 1'b0;
    end else if (!sel || cs_fall) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      tx_q     <= '0;
    end else if (rise) begin
      rx_q <= rx_full;
      if (bit_cnt == 3'd7) begin
        bit_cnt <= '0;
        tx_q    <= resp;
        if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
        if (first) begin
          cmd_q   <= rx_full;
          rd_ok_q <= status_q == ST_DONE;
        end
      end else begin
        bit_cnt <= bit_cnt + 3'd1;
      end
    end else if (fall && bit_cnt != '0) begin
      tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= ST_IDLE;
      eng_start <= 1'b0;
      res_q     <= '0;
    end else begin
      eng_start <= go_fire;
      if (go_fire) status_q <= ST_BUSY;
      else if (status_q == ST_BUSY && eng_done) begin
        status_q <= ST_DONE;
        res_q    <= eng_result;
      end else if (rd_fin) status_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/spi_cmd_poll_slave_chk.sv
module spi_cmd_poll_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] status_q,
  input logic       eng_start,
  input logic       eng_done
);
  assert_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_q != 2'd3);
  assert_idle_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 2'd0) |=> (status_q != 2'd2));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (status_q == 2'd1));
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  assert_done_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 2'd1 && eng_done) |=> (status_q == 2'd2));
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 2'd1 && !eng_done) |=> (status_q == 2'd1 && !eng_start));
  assert_done_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 2'd2) |=> (status_q != 2'd1));
endmodule

bind spi_cmd_poll_slave spi_cmd_poll_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status_q(status_q),
  .eng_start(eng_start), .eng_done(eng_done)
);

// File: tb/spi_cmd_poll_slave_tb.sv
module spi_cmd_poll_slave_tb;
  localparam int NB = 4;
  localparam int HP = 6;
  localparam int ENG_DELAY = 1500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, eng_start, eng_done = 1'b0;
  logic [NB*8-1:0] eng_result = 32'hDEADBEEF;
  int total = 0, bad = 0, starts = 0, eng_cnt = 0;

  always #5 clk = ~clk;

  spi_cmd_poll_slave #(.RES_BYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .eng_start(eng_start), .eng_done(eng_done),
    .eng_result(eng_result)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      eng_cnt <= 0;
      eng_done <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      if (eng_start) begin
        starts <= starts + 1;
        eng_cnt <= ENG_DELAY;
      end else if (eng_cnt == 1) begin
        eng_done <= 1'b1;
        eng_cnt <= 0;
      end else if (eng_cnt > 1) eng_cnt <= eng_cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      wt(HP);
      q[i] = miso;
      sclk = 1'b1;
      wt(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_on;
    cs_n = 1'b0;
    wt(HP);
  endtask

  task automatic cs_off;
    wt(HP);
    cs_n = 1'b1;
    wt(2 * HP);
  endtask

  task automatic cmd1(input logic [7:0] c, output logic [7:0] r0, output logic [7:0] r1);
    cs_on();
    xfer(c, r0);
    xfer(8'h00, r1);
    cs_off();
  endtask

  localparam logic [15:0] VEC [0:7] = '{
    16'h2000, 16'h5500, 16'h30FF, 16'h2000,
    16'h1000, 16'h2001, 16'h1000, 16'h2001
  };
  localparam string VTAG [0:7] = '{"R3", "R8", "R6", "R6", "R2", "R2", "R7", "R7"};

  initial begin
    logic [7:0] a, b;
    int polls;
    chk("R1 reset miso", {31'd0, miso}, 32'd0);
    chk("R1 reset eng_start", {31'd0, eng_start}, 32'd0);
    wt(4);
    rst_n = 1'b1;
    wt(4);

    for (int v = 0; v < 8; v++) begin
      cmd1(VEC[v][15:8], a, b);
      chk({VTAG[v], " cmd byte answer"}, {24'd0, a}, 32'd0);
      chk({VTAG[v], " response"}, {24'd0, b}, {24'd0, VEC[v][7:0]});
    end
    chk("R7 single launch while busy", starts, 1);

    polls = 0;
    b = 8'h01;
    while (b == 8'h01 && polls < 200) begin
      cmd1(8'h20, a, b);
      polls++;
    end
    chk("R4 done after polling", {24'd0, b}, 32'd2);
    chk("R3 polled more than once", {31'd0, polls > 1}, 32'd1);

    cmd1(8'h10, a, b);
    wt(4);
    chk("R7 start while done no pulse", starts, 1);
    cmd1(8'h20, a, b);
    chk("R7 status still done", {24'd0, b}, 32'd2);

    eng_result = 32'h0;
    cs_on();
    xfer(8'h20, a);
    xfer(8'h00, a);
    xfer(8'h00, b);
    cs_off();
    chk("R3 repeated status bytes", {16'd0, a, b}, 32'h0202);

    cs_on();
    xfer(8'h30, a);
    xfer(8'h00, a);
    xfer(8'h00, b);
    cs_off();
    chk("R5 partial read bytes", {16'd0, a, b}, 32'h0000DEAD);
    cmd1(8'h20, a, b);
    chk("R5 partial read keeps done", {24'd0, b}, 32'd2);

    cs_on();
    xfer(8'h30, a);
    for (int i = NB - 1; i >= 0; i--) begin
      xfer(8'h00, b);
      chk("R5 result byte", {24'd0, b}, {24'd0, 8'(32'hDEADBEEF >> (8 * i))});
    end
    xfer(8'h00, b);
    chk("R5 byte past result", {24'd0, b}, 32'd0);
    cs_off();
    cmd1(8'h20, a, b);
    chk("R5 full read returns idle", {24'd0, b}, 32'd0);
    chk("R8 miso low when deselected", {31'd0, miso}, 32'd0);

    eng_result = 32'h12345678;
    cmd1(8'h10, a, b);
    chk("R2 second launch", starts, 2);
    while (b != 8'h02) cmd1(8'h20, a, b);
    cs_on();
    xfer(8'h30, a);
    xfer(8'h00, a);
    cs_n = 1'b1;
    wt(4 * HP);
    cs_on();
    xfer(8'h30, a);
    xfer(8'h00, b);
    cs_off();
    chk("R9 aborted frame restarts at byte one", {24'd0, b}, 32'h12);

    cmd1(8'hA7, a, b);
    chk("R8 unknown cmd answer", {24'd0, b}, 32'd0);
    cmd1(8'h20, a, b);
    chk("R8 unknown cmd keeps done", {24'd0, b}, 32'd2);

    rst_n = 1'b0;
    wt(4);
    rst_n = 1'b1;
    wt(4);
    cmd1(8'h20, a, b);
    chk("R1 reset returns idle", {24'd0, b}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule